// File: doc/BRIEF.md
# MDIO Management Shift Controller

This block holds a 32-bit PHY management word and sends it to a PHY as one management frame on an MDIO/MDC pair. Software writes the word. The block then generates MDC from the system clock, sends a run of ones as a preamble, and streams the word out most significant bit first. At the same time it rotates the word in place: the bit leaving the top re-enters at the bottom as the value sampled on the MDIO line. A read of the word at any moment returns the live, partly rotated contents.

When the last bit has gone out, the word is back in its original bit order. For a read frame, the data field then holds the reply from the PHY. The block sets a done flag and pulses an interrupt request. The management frame can be a clause 22 or a clause 45 frame. The block tells them apart only by the operation bits of the word. It releases the MDIO line from the turnaround field onward whenever the word codes a read.

Top module: `mdio_shift_ctrl`

## Requirements
- R1: After reset, busy, done, irq, mdc and mdio_oe are low and rd_data is zero.
- R2: A write (wr_en high) while busy is low loads wr_data into the word, sets busy and clears done in the next cycle. A write while busy is high is ignored, including one in the cycle the frame completes: busy and done are not affected and the word is not reloaded.
- R3: MDC runs only while busy, with a period of 8 << div_sel system clocks (div_sel 0..3 gives 8, 16, 32, 64). Each period is low for its first half and high for its second half. MDC is low when idle. div_sel is captured when a write is accepted, so later changes do not affect the running frame.
- R4: A frame is 64 MDC periods, so busy stays high for exactly 64 x (8 << div_sel) system clocks (2048 at div_sel = 2). During the first 32 periods mdio_o is 1 with mdio_oe high. During period 32 + k, mdio_o carries bit 31 - k of the written word.
- R5: At the end of every word period the word rotates left by one place, and bit 0 takes the MDIO value sampled at the rising edge of MDC in that period. rd_data always shows the live word, so after k word periods it shows the written word rotated left by k.
- R6: At the end of a write frame (word bit 29 = 0), rd_data equals the written word.
- R7: A word with bit 29 = 1 is a read frame. This covers clause 22 read (bits 31:28 = 0110) and clause 45 read (0011). From word bit 17 (period 46) to the end of the frame, mdio_oe is low. Bits 17:16 and 15:0 of the final word then hold the line values sampled in those periods.
- R8: When a frame completes, busy falls, done rises, and irq is high for exactly that one cycle. done stays high until the next accepted write.
- R9: mdio_oe is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the management word |
| wr_data | input | 32 | Management word to send |
| div_sel | input | 2 | MDC divider select (8 << div_sel) |
| mdio_i | input | 1 | Sampled MDIO line |
| rd_data | output | 32 | Live contents of the management word |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | The last frame has completed |
| irq | output | 1 | One-cycle completion interrupt request |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Two events can meet in one cycle: the completion of a frame, and a software write that arrives in that same cycle. The bench counts the busy cycles of a running clause 45 read and asserts the write strobe so that it lands exactly on the completion edge. It then expects the write to be dropped: busy stays low, done stays high, and the final word holds the read data rather than the new value. A second, later write must then be accepted and must clear done.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int REG_W      = 32;
    localparam int PRE_LEN    = 32;
    localparam int FRAME_LEN  = PRE_LEN + REG_W;
    localparam int CNT_W      = $clog2(FRAME_LEN);
    localparam int DSEL_W     = 2;
    localparam int MIN_HALF   = 4;
    localparam int MAX_PERIOD = 2 * MIN_HALF * (1 << ((1 << DSEL_W) - 1));
    localparam int PH_W       = $clog2(MAX_PERIOD);
    localparam int RD_OP_BIT  = 29;
    localparam int TA_BIT     = 17;
    localparam int TA_IDX     = REG_W - 1 - TA_BIT;

    typedef struct packed {
        logic rise;
        logic fall;
    } mdc_tick_t;

    function automatic logic [PH_W-1:0] half_period(input logic [DSEL_W-1:0] sel);
        return PH_W'(MIN_HALF) << sel;
    endfunction

    function automatic logic is_read_word(input logic [REG_W-1:0] w);
        return w[RD_OP_BIT];
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic [DSEL_W-1:0] div_sel,
    output logic              mdc,
    output mdc_tick_t         tick
);
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] half_q;
    logic [PH_W:0]   period_m1;

    assign period_m1 = {half_q, 1'b0} - (PH_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            half_q <= PH_W'(MIN_HALF);
        end else if (start) begin
            phase  <= '0;
            half_q <= half_period(div_sel);
        end else if (run) begin
            phase <= tick.fall ? '0 : phase + 1'b1;
        end
    end

    assign mdc       = run && (phase >= half_q);
    assign tick.rise = run && (phase == half_q);
    assign tick.fall = run && ({1'b0, phase} == period_m1);
endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
    import mdio_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic load_rd,
    input  logic run,
    input  logic bit_end,
    input  logic msb,
    output logic mdio_o,
    output logic mdio_oe,
    output logic shift_ok,
    output logic last_bit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic             rd_q;
    logic             in_pre;
    logic             released;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            rd_q <= 1'b0;
        end else if (start) begin
            cnt  <= '0;
            rd_q <= load_rd;
        end else if (run && bit_end) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign in_pre   = cnt < CNT_W'(PRE_LEN);
    assign idx      = cnt - CNT_W'(PRE_LEN);
    assign released = rd_q && !in_pre && (idx >= CNT_W'(TA_IDX));
    assign mdio_oe  = run && !released;
    assign mdio_o   = run && (in_pre || msb);
    assign shift_ok = run && !in_pre;
    assign last_bit = cnt == CNT_W'(FRAME_LEN - 1);
endmodule

// File: rtl/mdio_shreg.sv
module mdio_shreg
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             mdio_i,
    input  mdc_tick_t        tick,
    input  logic             shift_ok,
    input  logic             last_bit,
    output logic [REG_W-1:0] word,
    output logic             busy,
    output logic             done,
    output logic             irq,
    output logic             start
);
    logic samp;

    assign start = wr_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp <= 1'b0;
        end else if (tick.rise) begin
            samp <= mdio_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                word <= wr_data;
                busy <= 1'b1;
                done <= 1'b0;
            end else if (busy && tick.fall) begin
                if (shift_ok) begin
                    word <= {word[REG_W-2:0], samp};
                end
                if (last_bit) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    irq  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_shift_ctrl.sv
module mdio_shift_ctrl
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [DSEL_W-1:0] div_sel,
    input  logic              mdio_i,
    output logic [REG_W-1:0]  rd_data,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    mdc_tick_t tick;
    logic      start;
    logic      shift_ok;
    logic      last_bit;

    mdio_mdc_gen u_mdc (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .run     (busy),
        .div_sel (div_sel),
        .mdc     (mdc),
        .tick    (tick)
    );

    mdio_framer u_frm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load_rd  (is_read_word(wr_data)),
        .run      (busy),
        .bit_end  (tick.fall),
        .msb      (rd_data[REG_W-1]),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .shift_ok (shift_ok),
        .last_bit (last_bit)
    );

    mdio_shreg u_sr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mdio_i   (mdio_i),
        .tick     (tick),
        .shift_ok (shift_ok),
        .last_bit (last_bit),
        .word     (rd_data),
        .busy     (busy),
        .done     (done),
        .irq      (irq),
        .start    (start)
    );
endmodule

// File: rtl/mdio_shift_ctrl_chk.sv
module mdio_shift_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        busy,
    input logic        done,
    input logic        irq,
    input logic        mdc,
    input logic        mdio_oe
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst) (wr_en && !busy) |=> (busy && !done)); // R2
    AST_DONE_CLR_ON_START: assert property (@(posedge clk) disable iff (rst) $fell(done) |-> busy); // R2
    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdc); // R3
    AST_WORD_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy) && !$fell(mdc)) |-> $stable(rd_data)); // R5
    AST_END_FLAGS: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (done && irq)); // R8
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> irq); // R8
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) irq |=> !irq); // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdio_oe); // R9
endmodule

bind mdio_shift_ctrl mdio_shift_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .busy    (busy),
    .done    (done),
    .irq     (irq),
    .mdc     (mdc),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_shift_ctrl_test.sv
module mdio_shift_ctrl_test;
    typedef struct {
        logic [31:0] val;
        int          cycles;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  div_sel = 2'd0;
    logic        mdio_i;
    logic [31:0] rd_data;
    logic        busy, done, irq, mdc, mdio_o, mdio_oe;

    int          n_tests = 0;
    int          n_fail = 0;
    int          negcnt = 0;
    int          busy_cnt = 0;
    int          frames_done = 0;
    logic [15:0] phy_data = '0;
    logic        phy_line;
    exp_t        sb[$];

    always #2 clk = ~clk;

    mdio_shift_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .div_sel(div_sel),
        .mdio_i(mdio_i), .rd_data(rd_data), .busy(busy), .done(done), .irq(irq),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always_comb begin
        int j;
        j = negcnt - 32;
        if (j == 14)                phy_line = 1'b1;
        else if (j == 15)           phy_line = 1'b0;
        else if (j >= 16 && j < 32) phy_line = phy_data[31-j];
        else                        phy_line = 1'b1;
    end
    assign mdio_i = mdio_oe ? mdio_o : phy_line;

    always @(negedge mdc) negcnt <= negcnt + 1;
    always @(negedge clk) if (busy) busy_cnt <= busy_cnt + 1;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [1:0] sel, input logic [15:0] pd);
        exp_t e;
        @(negedge clk);
        wr_data  = w;
        div_sel  = sel;
        wr_en    = 1'b1;
        negcnt   = 0;
        busy_cnt = 0;
        phy_data = pd;
        e.val    = w[29] ? {w[31:18], 2'b10, pd} : w;
        e.cycles = 64 * (8 << sel);
        sb.push_back(e);
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, "R2 start", {30'd0, busy, done}, 32'h2);
    endtask

    // scoreboard monitor
    always @(posedge irq) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
            chk(1'b0, "R8 unexpected irq", rd_data, 32'h0);
        end else begin
            e = sb.pop_front();
            chk(rd_data === e.val, "R6 R7 final word", rd_data, e.val);
            chk(busy_cnt == e.cycles, "R3 R4 frame length", busy_cnt, e.cycles);
            chk(done === 1'b1 && busy === 1'b0, "R8 done set", {30'd0, busy, done}, 32'h1);
        end
        @(negedge clk);
        chk(irq === 1'b0, "R8 irq one cycle", {31'd0, irq}, 32'h0);
        frames_done++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, irq, mdc, mdio_oe} === 5'b0 && rd_data === 32'h0, "R1 reset state",
            {busy, done, irq, mdc, mdio_oe, rd_data[26:0]}, 32'h0);

        // clause 45 address write, divide by 64
        w = {2'b00, 2'b00, 5'd3, 5'd1, 2'b10, 16'hBEEF};
        issue(w, 2'd3, 16'h0);
        wait (negcnt == 20);
        @(negedge clk);
        wr_data = 32'hFFFF_FFFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, "R2 ignored while busy", {30'd0, busy, done}, 32'h2);
        wait (negcnt == 31);
        @(negedge clk);
        chk(mdio_o === 1'b1 && mdio_oe === 1'b1 && rd_data === w, "R4 preamble last bit",
            {30'd0, mdio_o, mdio_oe}, 32'h3);
        wait (negcnt == 32);
        @(negedge clk);
        chk(mdio_o === w[31], "R4 first word bit", {31'd0, mdio_o}, {31'd0, w[31]});
        wait (negcnt == 40);
        @(negedge clk);
        chk(rd_data === {w[23:0], w[31:24]}, "R5 live rotation", rd_data, {w[23:0], w[31:24]});
        wait (frames_done == 1);
        @(negedge clk);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R3 R9 idle lines", {30'd0, mdc, mdio_oe}, 32'h0);

        // clause 22 read, divide by 16
        w = {2'b01, 2'b10, 5'd5, 5'd2, 2'b11, 16'h0000};
        issue(w, 2'd1, 16'hA5C3);
        wait (negcnt == 45);
        @(negedge clk);
        chk(mdio_oe === 1'b1, "R7 driven before turnaround", {31'd0, mdio_oe}, 32'h1);
        wait (negcnt == 46);
        @(negedge clk);
        chk(mdio_oe === 1'b0, "R7 released at turnaround", {31'd0, mdio_oe}, 32'h0);
        wait (frames_done == 2);

        // clause 45 read, divide by 32, write lands on completion edge
        w = {4'b0011, 5'd7, 5'd3, 2'b11, 16'hFFFF};
        issue(w, 2'd2, 16'h1234);
        wait (busy_cnt == 2048);
        wr_data = 32'h1357_9BDF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy === 1'b0 && done === 1'b1, "R2 write on completion ignored", {30'd0, busy, done}, 32'h1);
        wait (frames_done == 3);
        repeat (4) @(negedge clk);
        chk(done === 1'b1 && mdc === 1'b0 && mdio_oe === 1'b0, "R8 R9 done held idle",
            {29'd0, done, mdc, mdio_oe}, 32'h4);

        // clause 22 write, divide by 8, divider changed mid-frame
        w = {2'b01, 2'b01, 5'd1, 5'd4, 2'b10, 16'h5A5A};
        issue(w, 2'd0, 16'h0);
        div_sel = 2'd3;
        wait (frames_done == 4);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule